// File: doc/BRIEF.md
# Platform Reset Request Register

This block is a one-byte register that software writes to ask for a platform reset. A write that sets the trigger bit sends a one-cycle reset request to the platform's reset sequencer. That write does not change the stored byte. A write that leaves the trigger bit clear stores only the two reset-type mode bits and drops every other bit. The two stored mode bits also drive output pins, so the sequencer can tell whether a full or a system reset was selected.

The access port can be wider than one byte. Only the lowest byte of the write data is used. A read returns the stored byte in the low byte and zeros above it. The read path is combinational.

Top module: `rst_ctl_reg`

## Requirements
- R1: While `rst_n` is low and after it is released, the stored byte is 0x00, `reset_req`, `full_rst` and `sys_rst` are 0, and `rdata` is all zeros.
- R2: A write (`wr_en` high at a rising edge) with `wdata` bit 2 set drives `reset_req` high for exactly the cycle after that edge. Each such write in consecutive cycles gives one cycle of request.
- R3: A write with `wdata` bit 2 set leaves the stored byte unchanged, whatever the other bits hold.
- R4: A write with `wdata` bit 2 clear stores `wdata[7:0] & 8'h0A`. Only bit 3 (full reset) and bit 1 (system reset) are kept.
- R5: `rdata[7:0]` always equals the stored byte and `rdata` bits above 7 are always zero. A write becomes visible in the cycle after its edge.
- R6: `full_rst` equals stored bit 3 and `sys_rst` equals stored bit 1.
- R7: `wdata` bits above 7 have no effect. A set bit 10 does not trigger a request, and upper bits do not alter the stored value.
- R8: With `wr_en` low the stored byte holds. `reset_req` is high only in the cycle after a triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for this register |
| wdata | input | BUS_W | Write data; only bits 7:0 are used |
| rdata | output | BUS_W | Read data: stored byte, upper bits zero |
| reset_req | output | 1 | One-cycle platform reset request |
| full_rst | output | 1 | Stored full-reset mode bit |
| sys_rst | output | 1 | Stored system-reset mode bit |

## Verification
Assertions check these rules on every cycle:
- a trigger write is followed by a request and leaves the read value unchanged;
- a non-trigger write lands as the masked byte;
- an idle cycle changes nothing;
- no request appears without a trigger write;
- upper data bits never start a request;
- the store never holds a dropped bit.

The bench scenarios cover what the assertions do not:
- the exact value after reset;
- a reset taken in the middle of operation that clears bits set earlier;
- the two mode outputs following the stored byte;
- back-to-back trigger writes giving a two-cycle request;
- zeros in the upper read bits under wide write patterns.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int TRIG_BIT = 2;
  localparam int FULL_BIT = 3;
  localparam int SYS_BIT  = 1;
  localparam logic [7:0] KEEP_MASK = 8'((1 << FULL_BIT) | (1 << SYS_BIT));

  function automatic logic f_is_trigger(input logic [7:0] b);
    return b[TRIG_BIT];
  endfunction

  function automatic logic [7:0] f_retained(input logic [7:0] b);
    return b & KEEP_MASK;
  endfunction
endpackage

// File: rtl/rcr_wr_decode.sv
module rcr_wr_decode
  import rcr_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  output logic       trig_evt,
  output logic       keep_evt,
  output logic [7:0] keep_val
);
  always_comb begin
    trig_evt = wr_en && f_is_trigger(wbyte);
    keep_evt = wr_en && !f_is_trigger(wbyte);
    keep_val = f_retained(wbyte);
  end
endmodule

// File: rtl/rcr_mode_store.sv
module rcr_mode_store
  import rcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       keep_evt,
  input  logic [7:0] keep_val,
  output logic [7:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 8'h00;
    else if (keep_evt) mode_q <= keep_val;
  end

  AST_ONLY_KEPT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~KEEP_MASK) == 8'h00); // R4
endmodule

// File: rtl/rcr_req_pulse.sv
module rcr_req_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_evt,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= trig_evt;
  end
endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux #(
  parameter int BUS_W = 32
) (
  input  logic [7:0]       mode_q,
  output logic [BUS_W-1:0] rdata
);
  generate
    if (BUS_W > 8) begin : g_wide
      assign rdata = {{(BUS_W-8){1'b0}}, mode_q};
    end else begin : g_byte
      assign rdata = mode_q;
    end
  endgenerate
endmodule

// File: rtl/rst_ctl_reg.sv
module rst_ctl_reg
  import rcr_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             reset_req,
  output logic             full_rst,
  output logic             sys_rst
);
  logic       trig_evt;
  logic       keep_evt;
  logic [7:0] keep_val;
  logic [7:0] mode_q;
  logic       hi_bits_set;

  generate
    if (BUS_W > 8) begin : g_hi
      assign hi_bits_set = |wdata[BUS_W-1:8];
    end else begin : g_nohi
      assign hi_bits_set = 1'b0;
    end
  endgenerate

  rcr_wr_decode u_dec (
    .wr_en    (wr_en),
    .wbyte    (wdata[7:0]),
    .trig_evt (trig_evt),
    .keep_evt (keep_evt),
    .keep_val (keep_val)
  );

  rcr_mode_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .keep_evt (keep_evt),
    .keep_val (keep_val),
    .mode_q   (mode_q)
  );

  rcr_req_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_evt (trig_evt),
    .req_q    (reset_req)
  );

  rcr_read_mux #(.BUS_W(BUS_W)) u_rd (
    .mode_q (mode_q),
    .rdata  (rdata)
  );

  assign full_rst = mode_q[FULL_BIT];
  assign sys_rst  = mode_q[SYS_BIT];

  AST_TRIGGER_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[TRIG_BIT]) |=> reset_req); // R2
  AST_TRIGGER_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[TRIG_BIT]) |=> $stable(rdata)); // R3
  AST_STORE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[TRIG_BIT]) |=> (rdata[7:0] == ($past(wdata[7:0]) & 8'h0A))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rdata)); // R8
  AST_REQ_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_en && wdata[TRIG_BIT])); // R8
  AST_UPPER_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hi_bits_set && !wdata[TRIG_BIT]) |=> !reset_req); // R7
endmodule

// File: tb/sim_rst_ctl_reg.sv
module sim_rst_ctl_reg;
  localparam int BW = 32;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic          reset_req, full_rst, sys_rst;
  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'h00;
  bit finished = 0;

  always #5 clk = ~clk;

  rst_ctl_reg #(.BUS_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .reset_req(reset_req), .full_rst(full_rst), .sys_rst(sys_rst)
  );

  function automatic logic [7:0] kept(input logic [7:0] d);
    return {4'b0000, d[3], 1'b0, d[1], 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " R5 rdata"}, rdata, {24'h0, model});
    chk({tag, " R6 full_rst"}, {31'h0, full_rst}, {31'h0, model[3]});
    chk({tag, " R6 sys_rst"}, {31'h0, sys_rst}, {31'h0, model[1]});
  endtask

  // one write cycle; returns at the negedge after the write edge
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    if (!d[2]) model = kept(d[7:0]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 req in reset", {31'h0, reset_req}, 32'h0);
    rst_n = 1'b1;
    model = 8'h00;
    @(negedge clk);
    chk_state("R1 after reset");
    chk("R1 req after reset", {31'h0, reset_req}, 32'h0);
  endtask

  task automatic t_plain_store();
    logic [7:0] pats [4] = '{8'hFB, 8'h08, 8'h02, 8'h00};
    foreach (pats[i]) begin
      wr({24'h0, pats[i]});
      chk("R4 masked store", rdata, {24'h0, kept(pats[i])});
      chk("R8 no req on plain write", {31'h0, reset_req}, 32'h0);
      chk_state("R4");
    end
  endtask

  task automatic t_trigger();
    wr(32'h0000_000A);
    chk_state("R4 setup");
    wr(32'h0000_0004);
    chk("R2 req after trigger", {31'h0, reset_req}, 32'h1);
    chk("R3 value kept", rdata, 32'h0000_000A);
    @(negedge clk);
    chk("R2 req one cycle", {31'h0, reset_req}, 32'h0);
    wr(32'h0000_00F5);
    chk("R2 req after trigger ff", {31'h0, reset_req}, 32'h1);
    chk("R3 value kept ff", rdata, 32'h0000_000A);
    chk_state("R3");
    @(negedge clk);
    chk("R2 req dropped", {31'h0, reset_req}, 32'h0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    wr_en = 1'b1; wdata = 32'h4;
    @(negedge clk);
    chk("R2 first pulse", {31'h0, reset_req}, 32'h1);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    chk("R2 second pulse", {31'h0, reset_req}, 32'h1);
    @(negedge clk);
    chk("R2 pulse ends", {31'h0, reset_req}, 32'h0);
    chk_state("R3 b2b");
  endtask

  task automatic t_wide();
    wr(32'h0000_0408);
    chk("R7 bit10 no trigger", {31'h0, reset_req}, 32'h0);
    chk("R7 low byte only", rdata, 32'h0000_0008);
    wr(32'hFFFF_FF02);
    chk("R7 upper ignored", rdata, 32'h0000_0002);
    chk("R7 no req", {31'h0, reset_req}, 32'h0);
    chk_state("R7");
  endtask

  task automatic t_idle();
    wr(32'h0000_000A);
    for (int i = 0; i < 5; i++) begin
      wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R8 idle holds", rdata, 32'h0000_000A);
      chk("R8 idle no req", {31'h0, reset_req}, 32'h0);
    end
    wdata = '0;
  endtask

  task automatic t_reset_mid();
    wr(32'h0000_000A);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_plain_store();
    t_trigger();
    t_back_to_back();
    t_wide();
    t_idle();
    t_reset_mid();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule